// File: doc/BRIEF.md
# Sticky-Pending Masked Interrupt Controller

This block gathers 32 level-sensitive interrupt request lines into one interrupt output for a small processor. Each request line is first brought into the clock domain through a synchroniser. Its synchronised level is then merged into a pending word on every clock. A pending bit is set whenever its line is high, whatever the mask holds. The bit stays set until software acknowledges it. The processor output is the OR-reduction of pending AND mask, taken from a register.

Software uses a one-bit-address register port. Address 0 selects the mask: a write replaces the whole mask. Address 1 selects the pending word: a write clears every bit that is written as one. Both words can be read back combinationally. When a line is still high in the cycle its pending bit is acknowledged, the set takes priority, so such an acknowledge has no effect. The block also counts, for each line, the number of low-to-high transitions of the synchronised level. These 64-bit event counters are read through a separate index port.

Top module: `irq_sticky_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the mask, the pending word, every event counter and `cpu_irq` read as zero until an input or a write changes them.
- R2: A line that is high at `irq_req` on clock edge k sets its pending bit on edge k+2, whatever its mask bit holds. The bit stays set until it is acknowledged.
- R3: `cpu_irq` on edge k+1 equals the OR over all bits of (pending AND mask) as they stood after edge k.
- R4: A write with `reg_addr`=1 clears each pending bit whose `reg_wdata` bit is 1, provided its line is not high. Pending bits written as 0 keep their value.
- R5: A pending bit stays 1 when it is acknowledged in a cycle where its synchronised line is high (set wins over clear).
- R6: A write with `reg_addr`=0 replaces the whole mask with `reg_wdata`. `reg_rdata` shows the mask when `reg_addr`=0 and the pending word when `reg_addr`=1. It changes with the address in the same cycle.
- R7: The event counter of a line increments by one on each low-to-high transition of the synchronised line, two edges after the rise is sampled. It does not change while the line stays high, and it does not change when the line falls.
- R8: `cnt_value` shows, combinationally, the 64-bit event counter of the line selected by `cnt_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_req | input | 32 | Level-sensitive request lines, asynchronous to clk |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write access when reg_valid is high |
| reg_addr | input | 1 | 0 = mask, 1 = pending (write-one-to-clear) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| cnt_sel | input | 5 | Event counter index |
| cnt_value | output | 64 | Event counter of line cnt_sel |
| cpu_irq | output | 1 | Registered interrupt to the processor |

## Verification
The assertions assume that a write strobe lasts exactly one cycle per intended access. They also assume that `reg_addr` and `reg_wdata` are stable at the clock edge where the strobe is sampled. The bench drives every input only on the falling edge and drops `reg_valid` after each sampled edge, so no access is repeated by accident. Request lines change at random at most once per cycle. A line is held for several cycles in the directed cases, so rising edges and set-over-clear collisions happen on purpose and not only by chance.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int ISC_LINES  = 32;
  localparam int ISC_CNT_W  = 64;
  localparam int ISC_SYNC_N = 2;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_PEND = 1'b1
  } isc_sel_e;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int LINES  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_async,
  output logic [LINES-1:0] level,
  output logic [LINES-1:0] rise
);
  logic [LINES-1:0] stg_q [STAGES];
  logic [LINES-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [LINES-1:0] stg_d;
      if (s == 0) begin : g_first
        assign stg_d = req_async;
      end else begin : g_next
        assign stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg_q[STAGES-1];
  end

  assign level = stg_q[STAGES-1];
  assign rise  = stg_q[STAGES-1] & ~prev_q;

  AST_RISE_ONLY_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rise & $past(level)) == '0)); // R7
endmodule

// File: rtl/isc_core.sv
module isc_core #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] live,
  input  logic             mask_we,
  input  logic             ack_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] mask_o,
  output logic [LINES-1:0] pend_o,
  output logic             irq_o
);
  logic [LINES-1:0] mask_q, pend_q, pend_d, ack_bits;
  logic             irq_q, irq_d;

  always_comb begin
    ack_bits = ack_we ? wdata : '0;
    pend_d   = (pend_q & ~ack_bits) | live;
    irq_d    = |(pend_q & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  AST_LIVE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(live)) == $past(live))); // R2
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_we |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R2
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(pend_q) & $past(mask_q)))); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_we |=> ((pend_q & $past(wdata & ~live)) == '0)); // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wdata))); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q)); // R6
endmodule

// File: rtl/isc_evcnt.sv
module isc_evcnt #(
  parameter int LINES = 32,
  parameter int CNT_W = 64,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] rise,
  input  logic [IDX_W-1:0] sel,
  output logic [CNT_W-1:0] value
);
  logic [CNT_W-1:0] cnt_q [LINES];

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_lane
      logic [CNT_W-1:0] cnt_d;
      assign cnt_d = cnt_q[i] + {{(CNT_W-1){1'b0}}, 1'b1};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q[i] <= '0;
        else if (rise[i]) cnt_q[i] <= cnt_d;
      end

      AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> (cnt_q[i] == $past(cnt_q[i]) + 1'b1)); // R7
      AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rise[i] |=> $stable(cnt_q[i])); // R7
    end
  endgenerate

  assign value = cnt_q[sel];
endmodule

// File: rtl/irq_sticky_ctrl.sv
module irq_sticky_ctrl
  import isc_pkg::*;
#(
  parameter int LINES   = ISC_LINES,
  parameter int CNT_W   = ISC_CNT_W,
  parameter int SYNC_N  = ISC_SYNC_N,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_req,
  input  logic             reg_valid,
  input  logic             reg_write,
  input  logic             reg_addr,
  input  logic [LINES-1:0] reg_wdata,
  output logic [LINES-1:0] reg_rdata,
  input  logic [IDX_W-1:0] cnt_sel,
  output logic [CNT_W-1:0] cnt_value,
  output logic             cpu_irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [LINES-1:0] live, rise, mask_w, pend_w;
  logic             wr_en, mask_we, ack_we;
  isc_sel_e         sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sel     = isc_sel_e'(reg_addr);
  assign wr_en   = reg_valid & reg_write;
  assign mask_we = wr_en & (sel == SEL_MASK);
  assign ack_we  = wr_en & (sel == SEL_PEND);

  isc_sync #(.LINES(LINES), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .req_async(irq_req),
    .level(live), .rise(rise)
  );

  isc_core #(.LINES(LINES)) u_core (
    .clk(clk), .rst_n(rst_int_n), .live(live),
    .mask_we(mask_we), .ack_we(ack_we), .wdata(reg_wdata),
    .mask_o(mask_w), .pend_o(pend_w), .irq_o(cpu_irq)
  );

  isc_evcnt #(.LINES(LINES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .rise(rise),
    .sel(cnt_sel), .value(cnt_value)
  );

  always_comb begin
    unique case (sel)
      SEL_MASK: reg_rdata = mask_w;
      SEL_PEND: reg_rdata = pend_w;
      default:  reg_rdata = '0;
    endcase
  end

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(mask_we && ack_we)); // R6
endmodule

// File: tb/test_irq_sticky_ctrl.sv
module test_irq_sticky_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_req;
  logic        reg_valid, reg_write, reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [4:0]  cnt_sel;
  logic [63:0] cnt_value;
  logic        cpu_irq;

  int total = 0;
  int bad   = 0;

  logic [31:0] m_s1, m_s2, m_prev, m_pend, m_mask;
  logic        m_irq;
  logic [63:0] m_cnt [32];

  always #5 clk = ~clk;

  irq_sticky_ctrl i_irq_sticky_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cnt_sel(cnt_sel), .cnt_value(cnt_value), .cpu_irq(cpu_irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_pend(input logic [31:0] p, input logic [31:0] ack,
                                            input logic [31:0] lv);
    return (p & ~ack) | lv;
  endfunction

  task automatic model_clear();
    m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '0; m_irq = 1'b0;
    for (int i = 0; i < 32; i++) m_cnt[i] = '0;
  endtask

  task automatic model_edge(input logic [31:0] irq, input logic wv, input logic wa,
                            input logic [31:0] wd);
    logic [31:0] ack;
    ack   = (wv && wa) ? wd : '0;
    m_irq = |(m_pend & m_mask);
    for (int i = 0; i < 32; i++)
      if (m_s2[i] && !m_prev[i]) m_cnt[i] = m_cnt[i] + 64'd1;
    m_pend = next_pend(m_pend, ack, m_s2);
    if (wv && !wa) m_mask = wd;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = irq;
  endtask

  task automatic observe();
    reg_addr = 1'b0; #1;
    chk("R6 mask readback", {32'd0, reg_rdata}, {32'd0, m_mask});
    reg_addr = 1'b1; #1;
    chk("R2 pending readback", {32'd0, reg_rdata}, {32'd0, m_pend});
    cnt_sel = 5'($urandom_range(0, 31)); #1;
    chk("R7 event count", cnt_value, m_cnt[cnt_sel]);
    chk("R3 cpu_irq", {63'd0, cpu_irq}, {63'd0, m_irq});
  endtask

  task automatic step(input logic [31:0] irq, input logic wv, input logic wa,
                      input logic [31:0] wd);
    irq_req = irq; reg_valid = wv; reg_write = wv; reg_addr = wa; reg_wdata = wd;
    @(posedge clk);
    model_edge(irq, wv, wa, wd);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    observe();
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lv;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; irq_req = '0; reg_valid = 1'b0; reg_write = 1'b0;
    reg_addr = 1'b0; reg_wdata = '0; cnt_sel = '0;
    model_clear();
    repeat (3) @(negedge clk);
    reg_addr = 1'b0; #1; chk("R1 mask in reset", {32'd0, reg_rdata}, 64'd0);
    reg_addr = 1'b1; #1; chk("R1 pending in reset", {32'd0, reg_rdata}, 64'd0);
    chk("R1 cpu_irq in reset", {63'd0, cpu_irq}, 64'd0);
    chk("R1 counter in reset", cnt_value, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_addr = 1'b1; #1; chk("R1 pending after reset", {32'd0, reg_rdata}, 64'd0);
    cnt_sel = 5'd31; #1; chk("R1 counter after reset", cnt_value, 64'd0);

    // R2: masked-off line still pends; output stays low
    lv = 32'h0000_0008;
    for (int k = 0; k < 3; k++) step(lv, 1'b0, 1'b0, '0);
    reg_addr = 1'b1; #1;
    chk("R2 masked line pends", {63'd0, reg_rdata[3]}, 64'd1);
    chk("R3 masked stays low", {63'd0, cpu_irq}, 64'd0);
    // R6 + R3: unmask, output rises one edge later
    step(lv, 1'b1, 1'b0, 32'h0000_0008);
    chk("R3 no irq on mask edge", {63'd0, cpu_irq}, 64'd0);
    step(lv, 1'b0, 1'b0, '0);
    chk("R3 irq one edge after mask", {63'd0, cpu_irq}, 64'd1);
    // R5: ack while line held
    step(lv, 1'b1, 1'b1, 32'h0000_0008);
    reg_addr = 1'b1; #1;
    chk("R5 set wins over clear", {63'd0, reg_rdata[3]}, 64'd1);
    for (int k = 0; k < 5; k++) step(lv, 1'b0, 1'b0, '0);
    cnt_sel = 5'd3; #1;
    chk("R7 held line counts once", cnt_value, 64'd1);
    // R4: release, then ack clears; zero bits unaffected
    step('0, 1'b0, 1'b0, '0);
    step(32'h8000_0000, 1'b0, 1'b0, '0);
    for (int k = 0; k < 3; k++) step('0, 1'b0, 1'b0, '0);
    step('0, 1'b1, 1'b1, 32'h0000_0008);
    reg_addr = 1'b1; #1;
    chk("R4 acked bit cleared", {63'd0, reg_rdata[3]}, 64'd0);
    chk("R4 zero bit kept", {63'd0, reg_rdata[31]}, 64'd1);
    cnt_sel = 5'd3; #1;
    chk("R7 fall leaves count", cnt_value, 64'd1);
    cnt_sel = 5'd31; #1;
    chk("R8 counter index 31", cnt_value, 64'd1);
    step('0, 1'b0, 1'b0, '0);
    chk("R3 irq drops after ack", {63'd0, cpu_irq}, 64'd0);

    lv = '0;
    for (int n = 0; n < 3000; n++) begin
      logic wv, wa;
      logic [31:0] wd;
      if ($urandom_range(0, 3) == 0) lv = lv ^ (32'h1 << $urandom_range(0, 31));
      wv = ($urandom_range(0, 4) == 0);
      wa = 1'($urandom_range(0, 1));
      wd = $urandom();
      step(lv, wv, wa, wd);
    end
    for (int i = 0; i < 32; i++) begin
      cnt_sel = 5'(i); #0.1;
      chk("R8 counter sweep", cnt_value, m_cnt[i]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule